// File: doc/BRIEF.md
# Load-Merging Miss Tracker

This block keeps the list of cache misses that wait on the next memory level. A load miss comes in with its physical address, the number of its destination register and a code for how the returned data is formatted. The block compares the miss against every live load entry on the 32-byte block address. If a match can still take the load, the load joins that entry. If not, the load takes a free entry. A single returning fill then satisfies every load collected in the entry. Instruction fetch and prefetch misses use a separate, smaller group of entries, so they never take load capacity.

Each entry that waits sends one fill request, tagged with its entry number. Load entries use tags 0 to 5 and instruction entries use tags 6 to 9. A request leaves when the fill unit shows ready. When a fill comes back with a load tag, the block replays the loads collected in that entry, one per cycle. Each replay carries the register, the format code and the quadword position in the block. When a fill comes back with an instruction tag, the block reports the block address at once.

Top module: `load_merge_maf`

## Requirements
- R1: After reset no request, completion or stall is shown, and all ten entries are free.
- R2: A load miss that cannot merge takes the free load entry with the lowest number. Its request shows tag = entry number (0..5) and address = miss address with bits [4:0] cleared, from the cycle after the miss.
- R3: A load miss joins a live entry when address bits [31:5] are equal, the entry's request has not been accepted before this cycle and the entry holds fewer than 4 loads. This creates no new entry or request, and it works even when every load entry is busy.
- R4: A merge is refused if the matching entry already holds 4 loads or if its request was accepted in an earlier cycle. The miss then takes a new entry.
- R5: Only one request shows per cycle. A waiting load entry always goes before a waiting instruction entry, and the lowest number goes first within each group. A request counts as sent at an edge where req_valid and req_ready are both high.
- R6: From the cycle after a fill with a load tag, the block shows one completion per cycle for each load in the entry, in arrival order. Each completion carries the register, the format code and the quadword offset = address bits [4:3].
- R7: An entry frees at the edge that ends its last completion. The cycle after that edge, it can be allocated again.
- R8: ld_stall is high while a load miss is shown that can neither merge nor find a free load entry. While ld_stall is high, the miss is not taken. Instruction entries are never used for loads.
- R9: An instruction miss takes the lowest free instruction entry (tags 6..9). if_stall is high only when all four of these entries are busy, and it never affects the load side.
- R10: A fill with an instruction tag shows if_cpl_valid in the same cycle, with that entry's block address. The entry frees at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_miss_valid | input | 1 | Load miss shown |
| ld_miss_addr | input | 32 | Physical address of the load |
| ld_miss_reg | input | 5 | Destination register number |
| ld_miss_fmt | input | 3 | Data format code |
| ld_stall | output | 1 | Load miss cannot be taken this cycle |
| if_miss_valid | input | 1 | Instruction fetch or prefetch miss shown |
| if_miss_addr | input | 32 | Physical address of the fetch |
| if_stall | output | 1 | Instruction miss cannot be taken this cycle |
| req_valid | output | 1 | Fill request shown |
| req_ready | input | 1 | Fill unit accepts the request |
| req_tag | output | 4 | Entry number of the request |
| req_addr | output | 32 | Block address of the request |
| fill_valid | input | 1 | Fill returned |
| fill_tag | input | 4 | Entry number of the returned fill |
| cpl_valid | output | 1 | One merged load replayed |
| cpl_reg | output | 5 | Register of the replayed load |
| cpl_fmt | output | 3 | Format code of the replayed load |
| cpl_qw | output | 2 | Quadword offset of the replayed load |
| if_cpl_valid | output | 1 | Instruction fill done |
| if_cpl_addr | output | 32 | Block address of the instruction fill |

## Verification
The assertions assume the fill unit returns only tags whose requests it accepted, and returns each tag once per request. They also assume a miss held under a stall stays stable. The stimulus therefore sends fills only for entries whose request was seen accepted, and each tag is filled once. It keeps a stalled miss unchanged until the stall drops. It holds req_ready low whenever merges must find unsent entries.

// File: rtl/maf_pkg.sv
package maf_pkg;
  localparam int ADDR_W = 32;
  localparam int BLK_OFF = 5;
  localparam int QW_W = BLK_OFF - 3;
  localparam int BLK_W = ADDR_W - BLK_OFF;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BLK_W-1:0] blk_t;

  function automatic blk_t blk_of(addr_t a);
    return a[ADDR_W-1:BLK_OFF];
  endfunction

  function automatic logic [QW_W-1:0] qw_of(addr_t a);
    return a[BLK_OFF-1:3];
  endfunction

  function automatic addr_t blk_base(blk_t b);
    return {b, {BLK_OFF{1'b0}}};
  endfunction
endpackage

// File: rtl/maf_pick_low.sv
module maf_pick_low #(
  parameter int N = 6,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/maf_ifetch_part.sv
module maf_ifetch_part
  import maf_pkg::*;
#(
  parameter int N = 4,
  parameter int BASE = 6,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  addr_t            miss_addr,
  output logic             stall,
  output logic             pend_hit,
  output logic [TAG_W-1:0] pend_tag,
  output addr_t            pend_addr,
  input  logic             grant,
  input  logic             fill_valid,
  input  logic [TAG_W-1:0] fill_tag,
  output logic             done_valid,
  output addr_t            done_addr
);
  localparam int IW = $clog2(N);

  logic [N-1:0] vld, iss;
  blk_t         blk [N];
  logic         fr_hit, pd_hit;
  logic [IW-1:0] fr_idx, pd_idx, fl_idx;
  logic [TAG_W-1:0] rel;
  logic         fl_in;
  logic         take;

  maf_pick_low #(.N(N)) u_free (.req(~vld), .hit(fr_hit), .idx(fr_idx));
  maf_pick_low #(.N(N)) u_pend (.req(vld & ~iss), .hit(pd_hit), .idx(pd_idx));

  assign take      = miss_valid && fr_hit;
  assign stall     = miss_valid && !fr_hit;
  assign pend_hit  = pd_hit;
  assign pend_tag  = TAG_W'(BASE) + TAG_W'(pd_idx);
  assign pend_addr = blk_base(blk[pd_idx]);

  assign rel        = fill_tag - TAG_W'(BASE);
  assign fl_in      = fill_valid && (fill_tag >= TAG_W'(BASE)) && (rel < TAG_W'(N));
  assign fl_idx     = rel[IW-1:0];
  assign done_valid = fl_in && vld[fl_idx];
  assign done_addr  = blk_base(blk[fl_idx]);

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[i] <= 1'b0;
        iss[i] <= 1'b0;
        blk[i] <= '0;
      end else begin
        if (take && fr_idx == IW'(i)) begin
          vld[i] <= 1'b1;
          iss[i] <= 1'b0;
          blk[i] <= blk_of(miss_addr);
        end
        if (grant && pd_idx == IW'(i)) iss[i] <= 1'b1;
        if (done_valid && fl_idx == IW'(i)) vld[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/load_merge_maf.sv
module load_merge_maf
  import maf_pkg::*;
#(
  parameter int LD_N = 6,
  parameter int IF_N = 4,
  parameter int SLOTS = 4,
  parameter int REG_W = 5,
  parameter int FMT_W = 3,
  parameter int TAG_W = $clog2(LD_N + IF_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_miss_valid,
  input  logic [31:0]      ld_miss_addr,
  input  logic [REG_W-1:0] ld_miss_reg,
  input  logic [FMT_W-1:0] ld_miss_fmt,
  output logic             ld_stall,
  input  logic             if_miss_valid,
  input  logic [31:0]      if_miss_addr,
  output logic             if_stall,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [TAG_W-1:0] req_tag,
  output logic [31:0]      req_addr,
  input  logic             fill_valid,
  input  logic [TAG_W-1:0] fill_tag,
  output logic             cpl_valid,
  output logic [REG_W-1:0] cpl_reg,
  output logic [FMT_W-1:0] cpl_fmt,
  output logic [1:0]       cpl_qw,
  output logic             if_cpl_valid,
  output logic [31:0]      if_cpl_addr
);
  localparam int IW    = $clog2(LD_N);
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam int PTR_W = $clog2(SLOTS);

  // entry state
  logic [LD_N-1:0]  e_vld, e_iss, e_fill;
  blk_t             e_blk [LD_N];
  logic [CNT_W-1:0] e_cnt [LD_N];
  logic [PTR_W-1:0] e_ptr [LD_N];
  logic [REG_W-1:0] s_reg [LD_N][SLOTS];
  logic [FMT_W-1:0] s_fmt [LD_N][SLOTS];
  logic [QW_W-1:0]  s_qw  [LD_N][SLOTS];

  // named events
  logic [LD_N-1:0] mergeable, fill_vec;
  logic            mg_hit, fr_hit, pd_hit, cp_hit;
  logic [IW-1:0]   mg_idx, fr_idx, pd_idx, cp_idx;
  logic            ld_merge, ld_alloc, ld_grant, if_grant, cp_last;
  logic            ifp_hit;
  logic [TAG_W-1:0] ifp_tag;
  addr_t           ifp_addr;

  for (genvar i = 0; i < LD_N; i++) begin : g_cmp
    assign mergeable[i] = e_vld[i] && !e_iss[i] &&
                          (e_blk[i] == blk_of(ld_miss_addr)) &&
                          (e_cnt[i] < CNT_W'(SLOTS));
    assign fill_vec[i]  = fill_valid && (fill_tag == TAG_W'(i));
  end

  maf_pick_low #(.N(LD_N)) u_merge (.req(mergeable),       .hit(mg_hit), .idx(mg_idx));
  maf_pick_low #(.N(LD_N)) u_free  (.req(~e_vld),          .hit(fr_hit), .idx(fr_idx));
  maf_pick_low #(.N(LD_N)) u_pend  (.req(e_vld & ~e_iss),  .hit(pd_hit), .idx(pd_idx));
  maf_pick_low #(.N(LD_N)) u_cpl   (.req(e_fill),          .hit(cp_hit), .idx(cp_idx));

  assign ld_merge = ld_miss_valid && mg_hit;
  assign ld_alloc = ld_miss_valid && !mg_hit && fr_hit;
  assign ld_stall = ld_miss_valid && !mg_hit && !fr_hit;

  assign req_valid = pd_hit || ifp_hit;
  assign req_tag   = pd_hit ? TAG_W'(pd_idx) : ifp_tag;
  assign req_addr  = pd_hit ? blk_base(e_blk[pd_idx]) : ifp_addr;
  assign ld_grant  = req_ready && pd_hit;
  assign if_grant  = req_ready && !pd_hit && ifp_hit;

  assign cpl_valid = cp_hit;
  assign cpl_reg   = s_reg[cp_idx][e_ptr[cp_idx]];
  assign cpl_fmt   = s_fmt[cp_idx][e_ptr[cp_idx]];
  assign cpl_qw    = s_qw[cp_idx][e_ptr[cp_idx]];
  assign cp_last   = (CNT_W'(e_ptr[cp_idx]) + CNT_W'(1)) == e_cnt[cp_idx];

  for (genvar i = 0; i < LD_N; i++) begin : g_ent
    logic alloc_me, merge_me, cpl_me;
    assign alloc_me = ld_alloc && fr_idx == IW'(i);
    assign merge_me = ld_merge && mg_idx == IW'(i);
    assign cpl_me   = cp_hit && cp_idx == IW'(i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_vld[i]  <= 1'b0;
        e_iss[i]  <= 1'b0;
        e_fill[i] <= 1'b0;
        e_blk[i]  <= '0;
        e_cnt[i]  <= '0;
        e_ptr[i]  <= '0;
      end else begin
        if (alloc_me) begin
          e_vld[i]  <= 1'b1;
          e_iss[i]  <= 1'b0;
          e_fill[i] <= 1'b0;
          e_blk[i]  <= blk_of(ld_miss_addr);
          e_cnt[i]  <= CNT_W'(1);
          e_ptr[i]  <= '0;
        end else if (merge_me) begin
          e_cnt[i] <= e_cnt[i] + CNT_W'(1);
        end
        if (ld_grant && pd_idx == IW'(i)) e_iss[i] <= 1'b1;
        if (fill_vec[i] && e_vld[i] && e_iss[i]) e_fill[i] <= 1'b1;
        if (cpl_me) begin
          if (cp_last) begin
            e_vld[i]  <= 1'b0;
            e_iss[i]  <= 1'b0;
            e_fill[i] <= 1'b0;
          end else begin
            e_ptr[i] <= e_ptr[i] + PTR_W'(1);
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (alloc_me || merge_me) begin
        s_reg[i][alloc_me ? '0 : e_cnt[i][PTR_W-1:0]] <= ld_miss_reg;
        s_fmt[i][alloc_me ? '0 : e_cnt[i][PTR_W-1:0]] <= ld_miss_fmt;
        s_qw[i][alloc_me ? '0 : e_cnt[i][PTR_W-1:0]]  <= qw_of(ld_miss_addr);
      end
    end
  end

  maf_ifetch_part #(.N(IF_N), .BASE(LD_N), .TAG_W(TAG_W)) u_ifp (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (if_miss_valid),
    .miss_addr  (if_miss_addr),
    .stall      (if_stall),
    .pend_hit   (ifp_hit),
    .pend_tag   (ifp_tag),
    .pend_addr  (ifp_addr),
    .grant      (if_grant),
    .fill_valid (fill_valid),
    .fill_tag   (fill_tag),
    .done_valid (if_cpl_valid),
    .done_addr  (if_cpl_addr)
  );
endmodule

// File: rtl/maf_checker.sv
module maf_checker #(
  parameter int LD_N = 6,
  parameter int TAG_W = 4,
  parameter int IW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_stall,
  input logic             req_valid,
  input logic [TAG_W-1:0] req_tag,
  input logic [LD_N-1:0]  e_vld,
  input logic [LD_N-1:0]  e_iss,
  input logic             ld_merge,
  input logic [IW-1:0]    mg_idx,
  input logic             fill_valid,
  input logic [TAG_W-1:0] fill_tag,
  input logic             cpl_valid,
  input logic             cp_last,
  input logic [IW-1:0]    cp_idx
);
  // R8
  stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |-> (&e_vld));

  // R5
  load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_tag >= TAG_W'(LD_N)) |-> ((e_vld & ~e_iss) == '0));

  // R4
  merge_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_merge |-> !e_iss[mg_idx]);

  // R6
  fill_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_tag < TAG_W'(LD_N) && e_vld[fill_tag[IW-1:0]] &&
     e_iss[fill_tag[IW-1:0]]) |=> cpl_valid);

  // R7
  free_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cp_last) |=> !e_vld[$past(cp_idx)]);
endmodule

bind load_merge_maf maf_checker #(.LD_N(LD_N), .TAG_W(TAG_W), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_stall(ld_stall), .req_valid(req_valid),
  .req_tag(req_tag), .e_vld(e_vld), .e_iss(e_iss), .ld_merge(ld_merge),
  .mg_idx(mg_idx), .fill_valid(fill_valid), .fill_tag(fill_tag),
  .cpl_valid(cpl_valid), .cp_last(cp_last), .cp_idx(cp_idx)
);

// File: tb/sim_load_merge_maf.sv
`timescale 1ns/1ps
module sim_load_merge_maf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_miss_valid = 1'b0, if_miss_valid = 1'b0, req_ready = 1'b0, fill_valid = 1'b0;
  logic [31:0] ld_miss_addr = '0, if_miss_addr = '0;
  logic [4:0]  ld_miss_reg = '0;
  logic [2:0]  ld_miss_fmt = '0;
  logic [3:0]  fill_tag = '0;
  logic ld_stall, if_stall, req_valid, cpl_valid, if_cpl_valid;
  logic [3:0]  req_tag;
  logic [31:0] req_addr, if_cpl_addr;
  logic [4:0]  cpl_reg;
  logic [2:0]  cpl_fmt;
  logic [1:0]  cpl_qw;

  int vectors = 0;
  int errs = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  load_merge_maf u0 (
    .clk(clk), .rst_n(rst_n),
    .ld_miss_valid(ld_miss_valid), .ld_miss_addr(ld_miss_addr),
    .ld_miss_reg(ld_miss_reg), .ld_miss_fmt(ld_miss_fmt), .ld_stall(ld_stall),
    .if_miss_valid(if_miss_valid), .if_miss_addr(if_miss_addr), .if_stall(if_stall),
    .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag), .req_addr(req_addr),
    .fill_valid(fill_valid), .fill_tag(fill_tag),
    .cpl_valid(cpl_valid), .cpl_reg(cpl_reg), .cpl_fmt(cpl_fmt), .cpl_qw(cpl_qw),
    .if_cpl_valid(if_cpl_valid), .if_cpl_addr(if_cpl_addr)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // expected request: tag and block address computed from the miss address
  task automatic chk_req(input string rq, input int tag, input logic [31:0] addr);
    chk(rq, "req_valid", {31'd0, req_valid}, 32'd1);
    chk(rq, "req_tag", {28'd0, req_tag}, tag[31:0]);
    chk(rq, "req_addr", req_addr, addr & ~32'h1f);
  endtask

  // expected completion: quadword = address bits [4:3]
  task automatic chk_cpl(input string rq, input int rg, input int fm, input logic [31:0] addr);
    chk(rq, "cpl_valid", {31'd0, cpl_valid}, 32'd1);
    chk(rq, "cpl_reg", {27'd0, cpl_reg}, rg[31:0]);
    chk(rq, "cpl_fmt", {29'd0, cpl_fmt}, fm[31:0]);
    chk(rq, "cpl_qw", {30'd0, cpl_qw}, {30'd0, addr[4:3]});
  endtask

  task automatic tick();
    @(posedge clk);
    #4;
  endtask

  task automatic ld(input logic [31:0] a, input int rg, input int fm);
    ld_miss_valid = 1'b1;
    ld_miss_addr  = a;
    ld_miss_reg   = rg[4:0];
    ld_miss_fmt   = fm[2:0];
  endtask

  task automatic quiet();
    ld_miss_valid = 1'b0;
    if_miss_valid = 1'b0;
    fill_valid    = 1'b0;
  endtask

  task automatic fin();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    errs++;
    $display("FAIL watchdog: actual running expected done");
    fin();
  end

  initial begin
    repeat (3) @(posedge clk);
    #4;
    // R1 reset state
    chk("R1", "req_valid", {31'd0, req_valid}, 0);
    chk("R1", "cpl_valid", {31'd0, cpl_valid}, 0);
    chk("R1", "ld_stall", {31'd0, ld_stall}, 0);
    chk("R1", "if_cpl_valid", {31'd0, if_cpl_valid}, 0);
    rst_n = 1'b1;

    // four loads to one block merge; fifth refused as full (R3, R4)
    tick(); ld(32'h1008, 1, 1); #1;
    chk("R2", "first miss no req yet", {31'd0, req_valid}, 0);
    chk("R8", "ld_stall", {31'd0, ld_stall}, 0);
    tick(); ld(32'h1018, 2, 2); #1;
    chk_req("R2", 0, 32'h1008);
    tick(); ld(32'h1000, 3, 3);
    tick(); ld(32'h1010, 4, 4);
    tick(); ld(32'h101f, 5, 5); #1;
    chk("R4", "full entry no stall", {31'd0, ld_stall}, 0);
    tick(); ld(32'h2000, 6, 6);
    tick(); quiet(); if_miss_valid = 1'b1; if_miss_addr = 32'h3004; #1;
    chk("R9", "if_stall", {31'd0, if_stall}, 0);
    tick(); quiet(); req_ready = 1'b1; #1;
    chk_req("R5", 0, 32'h1000);
    tick(); #1; chk_req("R4", 1, 32'h1000);
    tick(); #1; chk_req("R5", 2, 32'h2000);
    tick(); #1; chk_req("R5", 6, 32'h3000);
    tick(); #1;
    chk("R3", "no further entries", {31'd0, req_valid}, 0);

    // merge refused after request accepted (R4)
    tick(); ld(32'h1004, 7, 7); #1;
    chk("R4", "ld_stall", {31'd0, ld_stall}, 0);
    tick(); quiet(); #1;
    chk_req("R4", 3, 32'h1000);
    tick();

    // fill entry 0: replay in arrival order (R6), reuse (R7)
    fill_valid = 1'b1; fill_tag = 4'd0; #1;
    tick(); quiet(); #1; chk_cpl("R6", 1, 1, 32'h1008);
    tick(); #1; chk_cpl("R6", 2, 2, 32'h1018);
    tick(); #1; chk_cpl("R6", 3, 3, 32'h1000);
    tick(); #1; chk_cpl("R6", 4, 4, 32'h1010);
    ld(32'h4000, 8, 0);
    tick(); quiet(); #1;
    chk("R6", "replay ended", {31'd0, cpl_valid}, 0);
    chk_req("R7", 4, 32'h4000);
    ld(32'h5000, 9, 1);
    tick(); quiet(); #1;
    chk_req("R7", 0, 32'h5000);
    tick();

    // all load entries busy: merge still works, stall otherwise (R3, R8)
    req_ready = 1'b0;
    ld(32'h6000, 10, 2); #1;
    chk("R8", "free entry 5", {31'd0, ld_stall}, 0);
    tick(); ld(32'h6008, 11, 3); #1;
    chk("R3", "merge with file full", {31'd0, ld_stall}, 0);
    tick(); ld(32'h7000, 12, 4); if_miss_valid = 1'b1; if_miss_addr = 32'h3100; #1;
    chk("R8", "ld_stall high", {31'd0, ld_stall}, 1);
    chk("R9", "if side unaffected", {31'd0, if_stall}, 0);
    tick(); if_miss_valid = 1'b0; fill_valid = 1'b1; fill_tag = 4'd1; #1;
    chk("R8", "still stalled", {31'd0, ld_stall}, 1);
    tick(); fill_valid = 1'b0; #1;
    chk_cpl("R6", 5, 5, 32'h101f);
    chk("R7", "not yet free", {31'd0, ld_stall}, 1);
    tick(); #1;
    chk("R7", "freed next cycle", {31'd0, ld_stall}, 0);
    tick(); quiet();

    // instruction side (R10, R9)
    fill_valid = 1'b1; fill_tag = 4'd6; #1;
    chk("R10", "if_cpl_valid", {31'd0, if_cpl_valid}, 1);
    chk("R10", "if_cpl_addr", if_cpl_addr, 32'h3000);
    tick(); quiet(); if_miss_valid = 1'b1; if_miss_addr = 32'h8000; #1;
    chk("R10", "if_cpl_valid low", {31'd0, if_cpl_valid}, 0);
    tick(); if_miss_addr = 32'h8020;
    tick(); if_miss_addr = 32'h8040;
    tick(); if_miss_addr = 32'h8060; ld(32'h6010, 13, 5); #1;
    chk("R9", "if_stall all busy", {31'd0, if_stall}, 1);
    chk("R9", "ld_stall independent", {31'd0, ld_stall}, 0);
    tick(); quiet(); req_ready = 1'b1; #1;
    chk_req("R5", 1, 32'h7000);
    tick(); #1; chk_req("R5", 5, 32'h6000);
    tick(); #1; chk_req("R9", 6, 32'h8000);
    tick(); #1; chk_req("R9", 7, 32'h3100);
    tick(); #1; chk_req("R9", 8, 32'h8020);
    tick(); #1; chk_req("R9", 9, 32'h8040);
    tick(); #1;
    chk("R5", "queue drained", {31'd0, req_valid}, 0);

    // three merged loads replay from entry 5 (R6)
    fill_valid = 1'b1; fill_tag = 4'd5;
    tick(); quiet(); #1; chk_cpl("R6", 10, 2, 32'h6000);
    tick(); #1; chk_cpl("R6", 11, 3, 32'h6008);
    tick(); #1; chk_cpl("R6", 13, 5, 32'h6010);
    tick(); #1;
    chk("R7", "entry 5 done", {31'd0, cpl_valid}, 0);
    tick();
    fin();
  end
endmodule